// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD fields: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year in the range 2000 to 2099. A free-running sub-second strobe drives an internal prescaler. Each time the prescaler wraps, the seconds field advances, and carries ripple up through the fields. Month length and leap years are taken into account.

Software reaches the fields through a flat register port. A write lands in one cycle, and the read data follows the address combinationally. The hour field carries its own format flags, so 12-hour AM/PM and 24-hour counting can be used without a separate mode register. A run/stop control holds the whole counter until software releases it. That control powers up stopped.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hours 0x00 (24-hour), weekday 0x01, date 0x01, month 0x01, year 0x00 and control 0x80.
- R2: While control bit 7 (address 7) is 1 the time and date do not change and the prescaler holds. Writing 0 there lets counting start.
- R3: With counting enabled, the seconds field advances exactly once for every TICKS_PER_SEC cycles that have `sub_tick` high.
- R4: A write to any time or date register (addresses 0 to 6) clears the prescaler, so the next advance comes only after a full TICKS_PER_SEC further ticks.
- R5: Seconds wrap 0x59 to 0x00 and advance minutes. Minutes wrap 0x59 to 0x00 and advance hours.
- R6: In 24-hour mode (hour bit 6 clear) the hour counts BCD 0x00 to 0x23 and wraps 0x23 to 0x00, which advances the day.
- R7: In 12-hour mode (hour bit 6 set, bit 5 = PM, bits 4:0 = BCD 01..12) hour 11 goes to 12 with PM inverted, and 12 goes to 01 with PM kept. Only 11 PM to 12 AM advances the day.
- R8: Weekday (address 3, bits 2:0) counts 1 to 7 and wraps 7 to 1 on each day advance.
- R9: The date wraps to 0x01 and the month advances after day 0x30 in April, June, September and November, and after day 0x31 in the other 30- and 31-day months.
- R10: February ends after day 0x29 when the year value is divisible by 4, and after day 0x28 otherwise.
- R11: Month wraps 0x12 to 0x01 and advances the year. Year wraps 0x99 to 0x00.
- R12: A write loads its field by the next cycle. Bits outside a field's width read 0: seconds, minutes and hours keep 7 bits, weekday 3, date 6, month 5, year 8, and control keeps only bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_tick | input | 1 | Sub-second strobe, TICKS_PER_SEC per second |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |

## Verification
A corrupted carry between fields shows on the first second boundary after a rollover value is loaded. Field values are therefore set one second before each boundary of interest, and every field is read right after the single advance. A prescaler that is off by one, or that is not cleared on a write, shows as a seconds change one tick early or late. It is caught by counting ticks and reading the seconds field after each one. A stuck halt or mode flag appears within one second as a frozen or wrongly formatted hour.

// File: rtl/bcd_clock_pkg.sv
// Package: register addresses and BCD helpers shared by the calendar counter.
// Assumes all field values are packed BCD with tens in the upper nibble.
package bcd_clock_pkg;

    localparam logic [2:0] ADDR_SEC  = 3'd0;
    localparam logic [2:0] ADDR_MIN  = 3'd1;
    localparam logic [2:0] ADDR_HOUR = 3'd2;
    localparam logic [2:0] ADDR_WDAY = 3'd3;
    localparam logic [2:0] ADDR_DATE = 3'd4;
    localparam logic [2:0] ADDR_MON  = 3'd5;
    localparam logic [2:0] ADDR_YEAR = 3'd6;
    localparam logic [2:0] ADDR_CTRL = 3'd7;

    // Increment a two-digit BCD value (no range wrap; caller handles limits).
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'h0};
        else
            return v + 8'd1;
    endfunction

    // Last valid BCD date of a month; leap rule uses year value mod 4.
    function automatic logic [5:0] last_date(input logic [4:0] mon, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        case (mon)
            5'h02:                      return (ybin[1:0] == 2'b00) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_prescaler.sv
// Divides the sub-second strobe down to a one-cycle seconds pulse.
// Assumes sub_tick is a single-cycle enable; clear has priority over counting.
module bcd_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic run,
    input  logic clear,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    // Terminal count detection and pulse qualification.
    always_comb begin
        at_last   = (cnt_q == LAST);
        sec_pulse = run && sub_tick && at_last && !clear;
    end

    // Sub-second counter: cleared on load, held while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && sub_tick)
            cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end

    generate
        if (TICKS_PER_SEC > 1) begin : g_spacing_checks
            // R4: a cleared prescaler cannot fire in the following cycle.
            assert_clear_delays_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> !sec_pulse);
            // R3: second pulses are never back to back.
            assert_pulse_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
                sec_pulse |=> !sec_pulse);
        end
    endgenerate
endmodule

// File: rtl/bcd_time_chain.sv
// Seconds, minutes and hours in BCD, with 12/24-hour hour format.
// Assumes hour bit 6 selects 12-hour mode and bit 5 is PM in that mode.
module bcd_time_chain
    import bcd_clock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_pulse,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hour,
    input  logic [6:0] wdata,
    output logic [6:0] sec,
    output logic [6:0] min,
    output logic [6:0] hour,
    output logic       day_carry
);
    logic       min_step, hour_step, hour_carry;
    logic [6:0] hour_next;
    logic [7:0] sec_inc, min_inc, h12_inc, h24_inc;

    // Carry chain between seconds, minutes and hours.
    always_comb begin
        min_step  = sec_pulse && (sec == 7'h59);
        hour_step = min_step && (min == 7'h59);
        sec_inc   = bcd_step({1'b0, sec});
        min_inc   = bcd_step({1'b0, min});
        h12_inc   = bcd_step({3'b000, hour[4:0]});
        h24_inc   = bcd_step({2'b00, hour[5:0]});
    end

    // Next hour value for both formats and the day carry.
    always_comb begin
        hour_carry = 1'b0;
        if (hour[6]) begin
            if (hour[4:0] == 5'h11) begin
                hour_next  = {1'b1, ~hour[5], 5'h12};
                hour_carry = hour[5];
            end else if (hour[4:0] == 5'h12) begin
                hour_next = {1'b1, hour[5], 5'h01};
            end else begin
                hour_next = {1'b1, hour[5], h12_inc[4:0]};
            end
        end else begin
            if (hour[5:0] == 6'h23) begin
                hour_next  = 7'h00;
                hour_carry = 1'b1;
            end else begin
                hour_next = {1'b0, h24_inc[5:0]};
            end
        end
        day_carry = hour_step && hour_carry;
    end

    // Seconds register: load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         sec <= 7'h00;
        else if (wr_sec)    sec <= wdata;
        else if (sec_pulse) sec <= (sec == 7'h59) ? 7'h00 : sec_inc[6:0];
    end

    // Minutes register: load or advance on seconds wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)        min <= 7'h00;
        else if (wr_min)   min <= wdata;
        else if (min_step) min <= (min == 7'h59) ? 7'h00 : min_inc[6:0];
    end

    // Hours register: load or advance on minutes wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)         hour <= 7'h00;
        else if (wr_hour)   hour <= wdata;
        else if (hour_step) hour <= hour_next;
    end

    assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && sec == 7'h59 && !wr_sec) |=> (sec == 7'h00));
    assert_midnight_24h_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_step && !hour[6] && hour[5:0] == 6'h23 && !wr_hour) |=> (hour == 7'h00));
    assert_pm_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_step && hour[6] && hour[4:0] == 5'h11 && !wr_hour) |=> (hour[5] != $past(hour[5])));
    assert_noon_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_step && hour[6] && hour[4:0] == 5'h12 && !wr_hour) |=> (hour[4:0] == 5'h01 && $stable(hour[5])));
endmodule

// File: rtl/bcd_date_chain.sv
// Weekday, date, month and year counters driven by the end-of-day carry.
// Assumes BCD fields; year 00..99 stands for 2000..2099.
module bcd_date_chain
    import bcd_clock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_carry,
    input  logic       wr_wday,
    input  logic       wr_date,
    input  logic       wr_mon,
    input  logic       wr_year,
    input  logic [7:0] wdata,
    output logic [2:0] wday,
    output logic [5:0] date,
    output logic [4:0] mon,
    output logic [7:0] year
);
    logic       mon_step, year_step;
    logic [7:0] date_inc, mon_inc, year_inc;

    // Month-end and year-end detection.
    always_comb begin
        mon_step  = day_carry && (date == last_date(mon, year));
        year_step = mon_step && (mon == 5'h12);
        date_inc  = bcd_step({2'b00, date});
        mon_inc   = bcd_step({3'b000, mon});
        year_inc  = bcd_step(year);
    end

    // Weekday register: 1..7 cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         wday <= 3'd1;
        else if (wr_wday)   wday <= wdata[2:0];
        else if (day_carry) wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
    end

    // Date register: wraps at the month's last day.
    always_ff @(posedge clk) begin
        if (!rst_n)         date <= 6'h01;
        else if (wr_date)   date <= wdata[5:0];
        else if (day_carry) date <= mon_step ? 6'h01 : date_inc[5:0];
    end

    // Month register: 01..12.
    always_ff @(posedge clk) begin
        if (!rst_n)        mon <= 5'h01;
        else if (wr_mon)   mon <= wdata[4:0];
        else if (mon_step) mon <= (mon == 5'h12) ? 5'h01 : mon_inc[4:0];
    end

    // Year register: 00..99.
    always_ff @(posedge clk) begin
        if (!rst_n)         year <= 8'h00;
        else if (wr_year)   year <= wdata;
        else if (year_step) year <= (year == 8'h99) ? 8'h00 : year_inc;
    end

    assert_wday_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && wday == 3'd7 && !wr_wday) |=> (wday == 3'd1));
    assert_date_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_step && !wr_date) |=> (date == 6'h01));
    assert_year_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (year_step && year == 8'h99 && !wr_year) |=> (year == 8'h00));
endmodule

// File: rtl/bcd_clock_core.sv
// Top of the BCD calendar counter: register port, run control, field chains.
// Assumes one register access per cycle; read data follows reg_addr directly.
module bcd_clock_core
    import bcd_clock_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    logic       halt_q;
    logic       sec_pulse, day_carry, time_load;
    logic [6:0] sec, min, hour;
    logic [2:0] wday;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;

    // Any write outside the control register reloads the prescaler.
    always_comb time_load = reg_wr && (reg_addr != ADDR_CTRL);

    // Stop flag: set at reset, software clears it to start counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b1;
        else if (reg_wr && reg_addr == ADDR_CTRL)
            halt_q <= reg_wdata[7];
    end

    bcd_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .run       (!halt_q),
        .clear     (time_load),
        .sec_pulse (sec_pulse)
    );

    bcd_time_chain u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .wr_sec    (reg_wr && reg_addr == ADDR_SEC),
        .wr_min    (reg_wr && reg_addr == ADDR_MIN),
        .wr_hour   (reg_wr && reg_addr == ADDR_HOUR),
        .wdata     (reg_wdata[6:0]),
        .sec       (sec),
        .min       (min),
        .hour      (hour),
        .day_carry (day_carry)
    );

    bcd_date_chain u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_carry (day_carry),
        .wr_wday   (reg_wr && reg_addr == ADDR_WDAY),
        .wr_date   (reg_wr && reg_addr == ADDR_DATE),
        .wr_mon    (reg_wr && reg_addr == ADDR_MON),
        .wr_year   (reg_wr && reg_addr == ADDR_YEAR),
        .wdata     (reg_wdata),
        .wday      (wday),
        .date      (date),
        .mon       (mon),
        .year      (year)
    );

    // Read multiplexer with unused bits forced to zero.
    always_comb begin
        case (reg_addr)
            ADDR_SEC:  reg_rdata = {1'b0, sec};
            ADDR_MIN:  reg_rdata = {1'b0, min};
            ADDR_HOUR: reg_rdata = {1'b0, hour};
            ADDR_WDAY: reg_rdata = {5'b0, wday};
            ADDR_DATE: reg_rdata = {2'b0, date};
            ADDR_MON:  reg_rdata = {3'b0, mon};
            ADDR_YEAR: reg_rdata = year;
            default:   reg_rdata = {halt_q, 7'b0};
        endcase
    end

    assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !reg_wr) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(date)));
    assert_no_pulse_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |-> !sec_pulse);
endmodule

// File: tb/bcd_clock_core_bench.sv
`timescale 1ns/1ps
module bcd_clock_core_bench;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bcd_clock_core #(.TICKS_PER_SEC(TPS)) u_bcd_clock_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_check(input string req, input string what, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, what, v, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sub_tick = 1'b1;
            @(negedge clk); sub_tick = 1'b0;
        end
    endtask

    task automatic load_eod(input logic [7:0] hr);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, hr);
    endtask

    task automatic t_reset();
        rd_check("R1", "sec", 3'd0, 8'h00);
        rd_check("R1", "min", 3'd1, 8'h00);
        rd_check("R1", "hour", 3'd2, 8'h00);
        rd_check("R1", "wday", 3'd3, 8'h01);
        rd_check("R1", "date", 3'd4, 8'h01);
        rd_check("R1", "month", 3'd5, 8'h01);
        rd_check("R1", "year", 3'd6, 8'h00);
        rd_check("R1", "ctrl", 3'd7, 8'h80);
    endtask

    task automatic t_halt_and_rate();
        ticks(3 * TPS);
        rd_check("R2", "sec frozen while stopped", 3'd0, 8'h00);
        wr(3'd7, 8'h00);
        rd_check("R2", "ctrl cleared", 3'd7, 8'h00);
        ticks(TPS - 1);
        rd_check("R3", "sec before full second", 3'd0, 8'h00);
        ticks(1);
        rd_check("R3", "sec after one second", 3'd0, 8'h01);
        ticks(TPS);
        rd_check("R3", "sec after two seconds", 3'd0, 8'h02);
        wr(3'd7, 8'h80);
        ticks(2 * TPS);
        rd_check("R2", "sec frozen after stop", 3'd0, 8'h02);
        wr(3'd7, 8'h00);
    endtask

    task automatic t_load_restarts();
        ticks(TPS - 1);
        wr(3'd1, 8'h10);
        rd_check("R12", "minute loaded", 3'd1, 8'h10);
        ticks(TPS - 1);
        rd_check("R4", "no advance before full second", 3'd0, 8'h02);
        ticks(1);
        rd_check("R4", "advance after full second", 3'd0, 8'h03);
    endtask

    task automatic t_full_rollover();
        load_eod(8'h23);
        wr(3'd3, 8'h07); wr(3'd4, 8'h31); wr(3'd5, 8'h12); wr(3'd6, 8'h99);
        ticks(TPS);
        rd_check("R5", "sec wrap", 3'd0, 8'h00);
        rd_check("R5", "min wrap", 3'd1, 8'h00);
        rd_check("R6", "hour 23->00", 3'd2, 8'h00);
        rd_check("R8", "wday 7->1", 3'd3, 8'h01);
        rd_check("R9", "date 31->01", 3'd4, 8'h01);
        rd_check("R11", "month 12->01", 3'd5, 8'h01);
        rd_check("R11", "year 99->00", 3'd6, 8'h00);
    endtask

    task automatic t_month_lengths();
        load_eod(8'h23);
        wr(3'd4, 8'h30); wr(3'd5, 8'h04); wr(3'd6, 8'h25);
        ticks(TPS);
        rd_check("R9", "april end date", 3'd4, 8'h01);
        rd_check("R9", "april end month", 3'd5, 8'h05);
        load_eod(8'h23);
        wr(3'd4, 8'h30); wr(3'd5, 8'h05);
        ticks(TPS);
        rd_check("R9", "may 30->31", 3'd4, 8'h31);
        rd_check("R9", "may month held", 3'd5, 8'h05);
    endtask

    task automatic t_february();
        load_eod(8'h23);
        wr(3'd4, 8'h28); wr(3'd5, 8'h02); wr(3'd6, 8'h23);
        ticks(TPS);
        rd_check("R10", "common year feb 28 -> date", 3'd4, 8'h01);
        rd_check("R10", "common year feb 28 -> month", 3'd5, 8'h03);
        load_eod(8'h23);
        wr(3'd4, 8'h28); wr(3'd5, 8'h02); wr(3'd6, 8'h24);
        ticks(TPS);
        rd_check("R10", "leap year feb 28 -> 29", 3'd4, 8'h29);
        rd_check("R10", "leap year month held", 3'd5, 8'h02);
        load_eod(8'h23);
        ticks(TPS);
        rd_check("R10", "leap year feb 29 -> date", 3'd4, 8'h01);
        rd_check("R10", "leap year feb 29 -> month", 3'd5, 8'h03);
    endtask

    task automatic t_twelve_hour();
        wr(3'd3, 8'h03);
        load_eod(8'h51);
        ticks(TPS);
        rd_check("R7", "11AM -> 12PM", 3'd2, 8'h72);
        rd_check("R7", "no day advance at noon", 3'd3, 8'h03);
        load_eod(8'h72);
        ticks(TPS);
        rd_check("R7", "12PM -> 1PM", 3'd2, 8'h61);
        load_eod(8'h71);
        ticks(TPS);
        rd_check("R7", "11PM -> 12AM", 3'd2, 8'h52);
        rd_check("R7", "day advance at midnight", 3'd3, 8'h04);
        load_eod(8'h52);
        ticks(TPS);
        rd_check("R7", "12AM -> 1AM", 3'd2, 8'h41);
    endtask

    task automatic t_field_masks();
        wr(3'd3, 8'hF5);
        rd_check("R12", "wday keeps 3 bits", 3'd3, 8'h05);
        wr(3'd5, 8'hE9);
        rd_check("R12", "month keeps 5 bits", 3'd5, 8'h09);
        wr(3'd7, 8'hFF);
        rd_check("R12", "ctrl keeps bit 7", 3'd7, 8'h80);
        wr(3'd7, 8'h7F);
        rd_check("R12", "ctrl low bits ignored", 3'd7, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halt_and_rate();
        t_load_restarts();
        t_full_rollover();
        t_month_lengths();
        t_february();
        t_twelve_hour();
        t_field_masks();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule